// File: doc/BRIEF.md
# Vectored Interrupt Controller

This block gathers up to 32 interrupt sources into one interrupt line for a single processor. Each source is captured in a status register. The status register is masked by an enable register to form a pending set. The lowest-numbered pending source is reported as a vector number. Software reaches the block through a simple word-indexed register port. It can acknowledge sources and set or clear enable bits with bit masks, so no read-modify-write sequence is needed.

The parameter `STICKY_MASK` fixes a capture mode for each source. In level mode the status bit copies the input on every sampled cycle. In sticky mode a high input sets the status bit, and only an acknowledge clears it. A two-bit master register controls the block: bit 1 turns input sampling on and bit 0 lets the processor line be driven. The processor line needs both bits set.

Top module: `vintc_top`

## Requirements
- R1: After a synchronous reset (`rst` high at a clock edge), status, enable and master read 0, pending reads 0, the vector reads 0xFFFFFFFF and `irq_out` is low.
- R2: Reads decode on word index `bus_addr`: 0 status, 1 pending, 2 enable, 6 vector, 7 master. Master holds its two stored bits in [1:0], and its bits [31:2] read 0. Index 3 (acknowledge), 4 (set-enable) and 5 (clear-enable) always read 0.
- R3: Pending always reads as status AND enable, after every write and every sampled input change.
- R4: The vector reads the index of the lowest set pending bit. When no bit is pending it reads 0xFFFFFFFF.
- R5: `irq_out` is high exactly when master bit 0 and master bit 1 are both set and at least one pending bit is set. This follows the stored registers with no added delay.
- R6: A write to index 3 clears every status bit whose data bit is 1 and leaves the other status bits alone.
- R7: A write to index 4 ORs the data into enable.
- R8: A write to index 5 clears the enable bits where the data is 1 and keeps the others.
- R9: Writes to index 0, 2 and 7 replace the stored value. While sampling is on, the input capture of the same cycle is still applied on top of a status write.
- R10: While master bit 1 is 0, input levels have no effect on status.
- R11: With sampling on, a level-mode source's status bit equals its input as sampled at the previous clock edge.
- R12: With sampling on, a sticky-mode source's status bit is set by a high input and kept when the input falls.
- R13: Writes to index 1 (pending) and index 6 (vector) change no stored state.
- R14: If an acknowledge and a high sticky input reach the same status bit in one cycle, the bit ends up set. The acknowledge is applied first and the capture after it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_we | input | 1 | Write strobe for one cycle |
| bus_addr | input | 3 | Word index of the register (byte offset divided by 4) |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr`, combinational |
| irq_src | input | 32 | Interrupt source levels |
| irq_out | output | 1 | Combined interrupt line to the processor |

## Verification
The bench targets these cases:
- **Same-cycle acknowledge.** An acknowledge arrives while a sticky input is still high. A design that applies the acknowledge after the capture would drop an interrupt that is still active.
- **Vector priority.** Two pending sources are active at once, and then none. A priority encoder built in the wrong direction would report the higher index, and one that forgets the empty case would report 0 rather than all ones.
- **Sampling disabled.** Inputs change while master bit 1 is clear. A design that samples anyway would show the change in status.
- **Master bit 0 clear.** Sources are pending while master bit 0 is clear. A design that ignores the gate would raise `irq_out`.
- **Status write in level mode.** A full status write is made while level-mode inputs are low. A design that orders the write after the capture would keep bits that should follow the inputs.
- **Read-only and strobe indices.** Writes go to the read-only indices, and reads come from the strobe indices. These cases expose decode slips that store data or return stale values.

// File: rtl/vintc_pkg.sv
package vintc_pkg;
  typedef enum logic [2:0] {
    IDX_STATUS = 3'd0,
    IDX_PEND   = 3'd1,
    IDX_ENABLE = 3'd2,
    IDX_ACK    = 3'd3,
    IDX_SETEN  = 3'd4,
    IDX_CLREN  = 3'd5,
    IDX_VECTOR = 3'd6,
    IDX_MASTER = 3'd7
  } reg_idx_e;

  localparam int MASTER_W   = 2;
  localparam int BIT_IRQ_EN = 0;  // gates the processor line
  localparam int BIT_SAMPLE = 1;  // gates input capture
endpackage

// File: rtl/vintc_ctrl.sv
module vintc_ctrl
  import vintc_pkg::*;
#(
  parameter int NUM_SRC = 32,
  parameter int DATA_W  = 32
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                we,
  input  logic [2:0]          addr,
  input  logic [DATA_W-1:0]   wdata,
  output logic [NUM_SRC-1:0]  enable_q,
  output logic [MASTER_W-1:0] master_q,
  output logic                wr_status,
  output logic                wr_ack,
  output logic [NUM_SRC-1:0]  mask
);
  reg_idx_e idx;
  logic [NUM_SRC-1:0] enable_d;

  assign idx       = reg_idx_e'(addr);
  assign mask      = wdata[NUM_SRC-1:0];
  assign wr_status = we && (idx == IDX_STATUS);
  assign wr_ack    = we && (idx == IDX_ACK);

  always_comb begin
    enable_d = enable_q;
    if (we) begin
      case (idx)
        IDX_ENABLE: enable_d = mask;
        IDX_SETEN:  enable_d = enable_q | mask;
        IDX_CLREN:  enable_d = enable_q & ~mask;
        default:    enable_d = enable_q;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      enable_q <= '0;
      master_q <= '0;
    end else begin
      enable_q <= enable_d;
      if (we && idx == IDX_MASTER) master_q <= wdata[MASTER_W-1:0];
    end
  end
endmodule

// File: rtl/vintc_src_bank.sv
module vintc_src_bank #(
  parameter int                 NUM_SRC     = 32,
  parameter logic [NUM_SRC-1:0] STICKY_MASK = '0
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               sample_en,
  input  logic [NUM_SRC-1:0] src_i,
  input  logic               wr_status,
  input  logic               wr_ack,
  input  logic [NUM_SRC-1:0] mask,
  output logic [NUM_SRC-1:0] status_q
);
  for (genvar g = 0; g < NUM_SRC; g++) begin : g_bit
    logic after_sw;  // value after software actions, before capture
    logic nxt;

    always_comb begin
      after_sw = status_q[g];
      if (wr_status) after_sw = mask[g];
      if (wr_ack && mask[g]) after_sw = 1'b0;
    end

    if (STICKY_MASK[g]) begin : g_sticky
      assign nxt = sample_en ? (after_sw | src_i[g]) : after_sw;
    end else begin : g_level
      assign nxt = sample_en ? src_i[g] : after_sw;
    end

    always_ff @(posedge clk) begin
      if (rst) status_q[g] <= 1'b0;
      else     status_q[g] <= nxt;
    end
  end
endmodule

// File: rtl/vintc_prio.sv
module vintc_prio #(
  parameter int NUM_SRC = 32,
  parameter int DATA_W  = 32
) (
  input  logic [NUM_SRC-1:0] pending,
  output logic [DATA_W-1:0]  vector,
  output logic               any
);
  function automatic logic [DATA_W-1:0] first_set(input logic [NUM_SRC-1:0] v);
    logic [DATA_W-1:0] r;
    r = '1;
    for (int i = NUM_SRC - 1; i >= 0; i--) begin
      if (v[i]) r = DATA_W'(i);
    end
    return r;
  endfunction

  assign vector = first_set(pending);
  assign any    = |pending;
endmodule

// File: rtl/vintc_top.sv
module vintc_top
  import vintc_pkg::*;
#(
  parameter int                 NUM_SRC     = 32,
  parameter int                 DATA_W      = 32,
  parameter logic [NUM_SRC-1:0] STICKY_MASK = '0
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_we,
  input  logic [2:0]        bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  input  logic [NUM_SRC-1:0] irq_src,
  output logic              irq_out
);
  localparam int PAD_W = DATA_W - NUM_SRC;

  logic [NUM_SRC-1:0]  enable_q;
  logic [NUM_SRC-1:0]  status_q;
  logic [NUM_SRC-1:0]  pending;
  logic [NUM_SRC-1:0]  mask;
  logic [MASTER_W-1:0] master_q;
  logic                wr_status;
  logic                wr_ack;
  logic                sample_en;
  logic [DATA_W-1:0]   vector;
  logic                any_pending;

  vintc_ctrl #(.NUM_SRC(NUM_SRC), .DATA_W(DATA_W)) ctrl_i (
    .clk(clk), .rst(rst), .we(bus_we), .addr(bus_addr), .wdata(bus_wdata),
    .enable_q(enable_q), .master_q(master_q), .wr_status(wr_status),
    .wr_ack(wr_ack), .mask(mask)
  );

  assign sample_en = master_q[BIT_SAMPLE];

  vintc_src_bank #(.NUM_SRC(NUM_SRC), .STICKY_MASK(STICKY_MASK)) bank_i (
    .clk(clk), .rst(rst), .sample_en(sample_en), .src_i(irq_src),
    .wr_status(wr_status), .wr_ack(wr_ack), .mask(mask), .status_q(status_q)
  );

  assign pending = status_q & enable_q;

  vintc_prio #(.NUM_SRC(NUM_SRC), .DATA_W(DATA_W)) prio_i (
    .pending(pending), .vector(vector), .any(any_pending)
  );

  assign irq_out = master_q[BIT_IRQ_EN] && master_q[BIT_SAMPLE] && any_pending;

  function automatic logic [DATA_W-1:0] widen(input logic [NUM_SRC-1:0] v);
    return {{PAD_W{1'b0}}, v};
  endfunction

  always_comb begin
    case (reg_idx_e'(bus_addr))
      IDX_STATUS: bus_rdata = widen(status_q);
      IDX_PEND:   bus_rdata = widen(pending);
      IDX_ENABLE: bus_rdata = widen(enable_q);
      IDX_VECTOR: bus_rdata = vector;
      IDX_MASTER: bus_rdata = {{(DATA_W-MASTER_W){1'b0}}, master_q};
      default:    bus_rdata = '0;
    endcase
  end
endmodule

// File: rtl/vintc_checker.sv
module vintc_checker #(
  parameter int                 NUM_SRC     = 32,
  parameter int                 DATA_W      = 32,
  parameter logic [NUM_SRC-1:0] STICKY_MASK = '0
) (
  input logic               clk,
  input logic               rst,
  input logic               bus_we,
  input logic [2:0]         bus_addr,
  input logic [DATA_W-1:0]  bus_wdata,
  input logic [NUM_SRC-1:0] irq_src,
  input logic [NUM_SRC-1:0] status_q,
  input logic [NUM_SRC-1:0] enable_q,
  input logic [1:0]         master_q,
  input logic [DATA_W-1:0]  vector,
  input logic               irq_out
);
  localparam int IW = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1;

  logic [NUM_SRC-1:0] pend_c;
  logic [NUM_SRC-1:0] below_vec;
  logic [NUM_SRC-1:0] wmask;
  logic               no_vec;

  assign pend_c    = status_q & enable_q;
  assign no_vec    = (vector == {DATA_W{1'b1}});
  assign below_vec = ~({NUM_SRC{1'b1}} << vector[IW-1:0]);
  assign wmask     = bus_wdata[NUM_SRC-1:0];

  assert_reset_clear_R1: assert property (@(posedge clk)
    $fell(rst) |-> (status_q == '0 && enable_q == '0 && master_q == '0 && !irq_out));

  assert_vector_lowest_R4: assert property (@(posedge clk) disable iff (rst)
    !no_vec |-> (pend_c[vector[IW-1:0]] && (pend_c & below_vec) == '0));

  assert_vector_empty_R4: assert property (@(posedge clk) disable iff (rst)
    no_vec |-> pend_c == '0);

  assert_irq_gate_R5: assert property (@(posedge clk) disable iff (rst)
    irq_out |-> (master_q == 2'b11 && !no_vec));

  assert_ack_clears_R6: assert property (@(posedge clk) disable iff (rst)
    (bus_we && bus_addr == 3'd3 && !master_q[1]) |=> (status_q & $past(wmask)) == '0);

  assert_set_enable_R7: assert property (@(posedge clk) disable iff (rst)
    (bus_we && bus_addr == 3'd4) |=> enable_q == ($past(enable_q) | $past(wmask)));

  assert_clr_enable_R8: assert property (@(posedge clk) disable iff (rst)
    (bus_we && bus_addr == 3'd5) |=> enable_q == ($past(enable_q) & ~$past(wmask)));

  assert_no_sample_R10: assert property (@(posedge clk) disable iff (rst)
    (!master_q[1] && !bus_we) |=> status_q == $past(status_q));

  assert_level_follow_R11: assert property (@(posedge clk) disable iff (rst)
    master_q[1] |=> ((status_q ^ $past(irq_src)) & ~STICKY_MASK) == '0);

  assert_sticky_hold_R12: assert property (@(posedge clk) disable iff (rst)
    (master_q[1] && !bus_we) |=> (($past(status_q) & STICKY_MASK) & ~status_q) == '0);

  assert_ro_write_R13: assert property (@(posedge clk) disable iff (rst)
    (bus_we && (bus_addr == 3'd1 || bus_addr == 3'd6)) |=>
      (enable_q == $past(enable_q) && master_q == $past(master_q)));
endmodule

bind vintc_top vintc_checker #(
  .NUM_SRC(NUM_SRC), .DATA_W(DATA_W), .STICKY_MASK(STICKY_MASK)
) chk_i (
  .clk(clk), .rst(rst), .bus_we(bus_we), .bus_addr(bus_addr),
  .bus_wdata(bus_wdata), .irq_src(irq_src), .status_q(status_q),
  .enable_q(enable_q), .master_q(master_q), .vector(vector), .irq_out(irq_out)
);

// File: tb/vintc_top_tb_top.sv
`timescale 1ns/1ps
module vintc_top_tb_top;
  localparam logic [31:0] STICKY = 32'hFFFF_0000;  // upper half sticky, lower half level
  localparam logic [31:0] NONE   = 32'hFFFF_FFFF;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        bus_we = 1'b0;
  logic [2:0]  bus_addr = 3'd0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic [31:0] irq_src = '0;
  logic        irq_out;
  int          errors = 0;
  int          checks = 0;
  logic        done = 1'b0;

  always #2.5 clk = ~clk;

  vintc_top #(.NUM_SRC(32), .DATA_W(32), .STICKY_MASK(STICKY)) dut_i (
    .clk(clk), .rst(rst), .bus_we(bus_we), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq_src(irq_src),
    .irq_out(irq_out)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_we = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_we = 1'b0; bus_wdata = '0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [31:0] d);
    bus_addr = a;
    #0.5;
    d = bus_rdata;
  endtask

  // bench model of the vector rule
  function automatic logic [31:0] low_index(input logic [31:0] v);
    for (int i = 0; i < 32; i++) if (v[i]) return 32'(i);
    return NONE;
  endfunction

  task automatic t_reset();
    logic [31:0] d;
    rd(3'd0, d); check("R1 status", d, 0);
    rd(3'd2, d); check("R1 enable", d, 0);
    rd(3'd7, d); check("R1 master", d, 0);
    rd(3'd1, d); check("R1 pending", d, 0);
    rd(3'd6, d); check("R1 vector", d, NONE);
    check("R1 irq", {31'b0, irq_out}, 0);
  endtask

  task automatic t_no_sample();
    logic [31:0] d;
    irq_src = 32'hFFFF_FFFF;
    step(3);
    rd(3'd0, d); check("R10 status ignores inputs", d, 0);
    wr(3'd0, 32'h0001_0005);
    rd(3'd0, d); check("R9 status write", d, 32'h0001_0005);
    wr(3'd3, 32'h0000_0004);
    rd(3'd0, d); check("R6 ack clears only masked", d, 32'h0001_0001);
    wr(3'd7, 32'hFFFF_FFFD);
    rd(3'd7, d); check("R2 master upper bits zero", d, 32'h1);
    wr(3'd0, 0);
    wr(3'd7, 0);
    irq_src = '0;
  endtask

  task automatic t_enable();
    logic [31:0] d;
    wr(3'd2, 32'h0000_0F00);
    rd(3'd2, d); check("R9 enable replace", d, 32'h0000_0F00);
    wr(3'd4, 32'h0000_00F0);
    rd(3'd2, d); check("R7 set-enable", d, 32'h0000_0FF0);
    wr(3'd5, 32'h0000_0F3C);
    rd(3'd2, d); check("R8 clear-enable", d, 32'h0000_00C0);
    wr(3'd4, 32'h0010_0003);
    rd(3'd2, d); check("R7 set-enable again", d, 32'h0010_00C3);
    rd(3'd3, d); check("R2 ack reads 0", d, 0);
    rd(3'd4, d); check("R2 set reads 0", d, 0);
    rd(3'd5, d); check("R2 clear reads 0", d, 0);
  endtask

  task automatic t_level();
    logic [31:0] d, s, e;
    wr(3'd7, 32'h3);
    irq_src = 32'h0000_0040;
    step(1);
    rd(3'd0, s); check("R11 level follows", s, 32'h40);
    rd(3'd2, e);
    rd(3'd1, d); check("R3 pending", d, s & e);
    rd(3'd6, d); check("R4 vector", d, low_index(s & e));
    check("R5 irq on", {31'b0, irq_out}, 1);
    irq_src = 32'h0000_0042;
    step(1);
    rd(3'd6, d); check("R4 lowest wins", d, 1);
    irq_src = '0;
    step(1);
    rd(3'd0, d); check("R11 level falls", d, 0);
    rd(3'd6, d); check("R4 empty vector", d, NONE);
    check("R5 irq off", {31'b0, irq_out}, 0);
  endtask

  task automatic t_sticky();
    logic [31:0] d;
    irq_src = 32'h0010_0000;
    step(1);
    irq_src = '0;
    step(2);
    rd(3'd0, d); check("R12 sticky holds", d, 32'h0010_0000);
    rd(3'd6, d); check("R4 vector sticky", d, 20);
    check("R5 irq sticky", {31'b0, irq_out}, 1);
    wr(3'd7, 32'h2);
    check("R5 irq gated by bit0", {31'b0, irq_out}, 0);
    rd(3'd1, d); check("R3 pending with bit0 clear", d, 32'h0010_0000);
    wr(3'd7, 32'h3);
    wr(3'd3, 32'h0010_0000);
    rd(3'd0, d); check("R6 ack sticky", d, 0);
    rd(3'd6, d); check("R4 vector after ack", d, NONE);
  endtask

  task automatic t_same_cycle();
    logic [31:0] d;
    irq_src = 32'h0010_0000;
    step(1);
    wr(3'd3, 32'h0010_0000);
    rd(3'd0, d); check("R14 capture after ack", d, 32'h0010_0000);
    irq_src = '0;
    step(1);
    wr(3'd3, 32'h0010_0000);
    rd(3'd0, d); check("R14 ack once input low", d, 0);
  endtask

  task automatic t_status_write_sampling();
    logic [31:0] d;
    wr(3'd0, 32'hFFFF_FFFF);
    rd(3'd0, d); check("R9 status write under capture", d, 32'hFFFF_0000);
    wr(3'd3, 32'hFFFF_FFFF);
    rd(3'd0, d); check("R6 ack all", d, 0);
  endtask

  task automatic t_read_only();
    logic [31:0] d;
    irq_src = 32'h0000_0080;
    step(1);
    wr(3'd1, 32'h0000_0000);
    wr(3'd6, 32'h0000_0003);
    rd(3'd1, d); check("R13 pending unchanged", d, 32'h80);
    rd(3'd6, d); check("R13 vector unchanged", d, 7);
    rd(3'd2, d); check("R13 enable unchanged", d, 32'h0010_00C3);
    rd(3'd7, d); check("R13 master unchanged", d, 3);
    irq_src = '0;
    step(1);
  endtask

  task automatic t_reset_again();
    logic [31:0] d;
    irq_src = 32'h0000_0001;
    step(1);
    @(negedge clk); rst = 1'b1;
    @(negedge clk); rst = 1'b0;
    irq_src = '0;
    rd(3'd0, d); check("R1 status after reset", d, 0);
    rd(3'd7, d); check("R1 master after reset", d, 0);
    check("R1 irq after reset", {31'b0, irq_out}, 0);
  endtask

  initial begin
    step(3);
    rst = 1'b0;
    t_reset();
    t_no_sample();
    t_enable();
    t_level();
    t_sticky();
    t_same_cycle();
    t_status_write_sampling();
    t_read_only();
    t_reset_again();
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog (all requirements) actual=running expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule